// File: doc/BRIEF.md
# Colour Matrix Coefficient Converter

This block takes the nine coefficients of a colour-correction matrix and converts each one into the short fixed-point word that a pixel pipeline uses. Each input is a 64-bit sign-magnitude number with 32 fraction bits. Each output is a 15-bit two's-complement word with 12 fraction bits and 3 integer bits. As each coefficient is converted, the block also checks that it fits in the narrow format.

A producer sends the coefficients one per cycle with a valid strobe and an index, in index order. After the last coefficient, or after an index arrives out of order, the block gives a one-cycle completion pulse with an error flag. The nine converted words are loaded into the active output registers together, in one clock edge, and only when the whole set was clean. A downstream matrix therefore never sees a mixture of an old set and a new set.

Top module: `cmx_coef_conv`

## Requirements
- R1: While reset is held and after it is released, `set_done` and `set_err` are 0 and every active coefficient word on `coef_out` is 0.
- R2: For an input whose bit 63 is 0, the converted word is input bits 34:20 unchanged. Input bits 62:35 and 19:0 have no effect on the word.
- R3: For an input whose bit 63 is 1, the converted word is the 15-bit two's complement of input bits 34:20. Example: field 0x1000 gives 0x7000, and field 0x2000 gives 0x6000.
- R4: A coefficient is in error when input bit 63 differs from bit 14 of its converted word. A positive field of 0x4000 or more is an error. A negative field of 0 is an error. Negative fields 0x2000 and 0x4000 are not errors.
- R5: `cfg_index` must be 0, 1, …, 8 on successive accepted strobes. A strobe whose index differs from the expected one ends the set: `set_done` and `set_err` are 1 in the next cycle, that coefficient is discarded, and the next accepted index is 0 again.
- R6: When index 8 is accepted, `set_done` is 1 in the next cycle. `set_err` is 1 in that cycle exactly when at least one coefficient of the set was in error, including index 8 itself.
- R7: A set with no error loads all nine words at once, at the same edge that raises `set_done`. Word i appears at `coef_out[15*i +: 15]`.
- R8: A set that ends with `set_err` = 1 leaves `coef_out` exactly as it was. `coef_out` changes at no other time than with a clean completion.
- R9: Cycles with `cfg_valid` low change nothing. Gaps between coefficients are allowed. Index 0 of a new set may arrive in the cycle directly after index 8 of the previous set.
- R10: `set_done` is 1 for exactly one cycle per completed or aborted set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | A coefficient is present this cycle |
| cfg_index | input | 4 | Position of the coefficient within the set |
| cfg_data | input | 64 | Sign-magnitude coefficient with 32 fraction bits |
| set_done | output | 1 | One-cycle pulse: a set has completed or been aborted |
| set_err | output | 1 | Qualifies `set_done`: the set was rejected |
| coef_out | output | 135 | The nine active 15-bit words; word i is at bits 15*i+14 down to 15*i |

## Verification
Two events can land in the same cycle. The first is the set-closing coefficient raising an overflow, which the error flag has to absorb along with the completion pulse. The second is the first coefficient of a new set arriving while the previous set's completion is still being reported, which must start from a clear error history and expected index 0. The bench provokes the first case by placing out-of-range values at index 8 in both directed and random sets. It provokes the second by sending sets back to back with no idle cycle between them. A behavioural model built on a queue predicts the pulse, the flag and all nine words on every clock, so any error or index state leaking from one set into the next is caught.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

   // What the sequence tracker decided about the current cycle's strobe.
   typedef enum logic [1:0] {
      EVT_NONE   = 2'd0,   // no strobe
      EVT_ACCEPT = 2'd1,   // in-order coefficient, not the last
      EVT_LAST   = 2'd2,   // in-order coefficient that closes the set
      EVT_ABORT  = 2'd3    // out-of-order index
   } cmx_evt_e;

endpackage

// File: rtl/cmx_fx_convert.sv
module cmx_fx_convert #(
   parameter int IN_W       = 64,
   parameter int OUT_W      = 15,
   parameter int FRAC_SHIFT = 20
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] word,
   output logic             ovf
);
   localparam int SIGN_POS  = IN_W - 1;
   localparam int FIELD_MSB = FRAC_SHIFT + OUT_W - 1;

   if (FIELD_MSB >= SIGN_POS) begin : g_bad_field
      $error("cmx_fx_convert: magnitude field overlaps the sign bit");
   end

   logic             sign;
   logic [OUT_W-1:0] field;

   always_comb begin
      sign  = din[SIGN_POS];
      field = din[FIELD_MSB:FRAC_SHIFT];
      // negate first; range is judged on the result, not on the field
      word  = sign ? (~field + OUT_W'(1)) : field;
      ovf   = sign ^ word[OUT_W-1];
   end

endmodule

// File: rtl/cmx_seq_tracker.sv
module cmx_seq_tracker
   import cmx_pkg::*;
#(
   parameter int NUM_COEF = 9,
   parameter int IDX_W    = $clog2(NUM_COEF)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic [IDX_W-1:0] index,
   input  logic             coef_ovf,
   output cmx_evt_e         evt,
   output logic             commit,
   output logic             done,
   output logic             done_err
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_COEF - 1);

   if (NUM_COEF < 2) begin : g_bad_count
      $error("cmx_seq_tracker: a set needs at least two coefficients");
   end

   logic [IDX_W-1:0] exp_q;
   logic             bad_q;
   logic             bad_now;

   always_comb begin
      bad_now = bad_q | coef_ovf;
      if (!strobe)                 evt = EVT_NONE;
      else if (index != exp_q)     evt = EVT_ABORT;
      else if (exp_q == LAST_IDX)  evt = EVT_LAST;
      else                         evt = EVT_ACCEPT;
      commit = (evt == EVT_LAST) && !bad_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q    <= '0;
         bad_q    <= 1'b0;
         done     <= 1'b0;
         done_err <= 1'b0;
      end else begin
         done     <= 1'b0;
         done_err <= 1'b0;
         unique case (evt)
            EVT_ACCEPT: begin
               exp_q <= exp_q + IDX_W'(1);
               bad_q <= bad_now;
            end
            EVT_LAST: begin
               exp_q    <= '0;
               bad_q    <= 1'b0;
               done     <= 1'b1;
               done_err <= bad_now;
            end
            EVT_ABORT: begin
               exp_q    <= '0;
               bad_q    <= 1'b0;
               done     <= 1'b1;
               done_err <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exp_q <= LAST_IDX);

   assert_abort_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && index != exp_q) |=> (done && done_err));

   assert_last_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt == EVT_LAST && coef_ovf) |=> done_err);

   assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (exp_q == '0));

endmodule

// File: rtl/cmx_coef_bank.sv
module cmx_coef_bank #(
   parameter int NUM_COEF = 9,
   parameter int OUT_W    = 15,
   parameter int IDX_W    = $clog2(NUM_COEF)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [OUT_W-1:0]          wr_word,
   input  logic                      commit,
   output logic [NUM_COEF*OUT_W-1:0] coef_flat
);
   localparam int LAST = NUM_COEF - 1;

   logic [OUT_W-1:0] active_q [NUM_COEF];

   for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef
      if (i < LAST) begin : g_staged
         // staged until the whole set is known clean
         logic [OUT_W-1:0] shadow_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 shadow_q <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))       shadow_q <= wr_word;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       active_q[i] <= '0;
            else if (commit)  active_q[i] <= shadow_q;
         end
      end else begin : g_tail
         // closing coefficient goes straight to the active copy
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       active_q[i] <= '0;
            else if (commit)  active_q[i] <= wr_word;
         end
      end
      assign coef_flat[i*OUT_W +: OUT_W] = active_q[i];
   end

   assert_tail_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (active_q[LAST] == $past(wr_word)));

endmodule

// File: rtl/cmx_coef_conv.sv
module cmx_coef_conv
   import cmx_pkg::*;
#(
   parameter int NUM_COEF   = 9,
   parameter int IN_W       = 64,
   parameter int OUT_W      = 15,
   parameter int FRAC_SHIFT = 20,
   localparam int IDX_W     = $clog2(NUM_COEF),
   localparam int BUS_W     = NUM_COEF * OUT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_valid,
   input  logic [IDX_W-1:0] cfg_index,
   input  logic [IN_W-1:0]  cfg_data,
   output logic             set_done,
   output logic             set_err,
   output logic [BUS_W-1:0] coef_out
);
   if (OUT_W < 2 || FRAC_SHIFT < 0) begin : g_bad_fmt
      $error("cmx_coef_conv: unsupported output format");
   end

   logic [OUT_W-1:0] conv_word;
   logic             conv_ovf;
   cmx_evt_e         evt;
   logic             commit;

   cmx_fx_convert #(
      .IN_W      (IN_W),
      .OUT_W     (OUT_W),
      .FRAC_SHIFT(FRAC_SHIFT)
   ) u_conv (
      .din (cfg_data),
      .word(conv_word),
      .ovf (conv_ovf)
   );

   cmx_seq_tracker #(
      .NUM_COEF(NUM_COEF),
      .IDX_W   (IDX_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (cfg_valid),
      .index   (cfg_index),
      .coef_ovf(conv_ovf),
      .evt     (evt),
      .commit  (commit),
      .done    (set_done),
      .done_err(set_err)
   );

   cmx_coef_bank #(
      .NUM_COEF(NUM_COEF),
      .OUT_W   (OUT_W),
      .IDX_W   (IDX_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (evt == EVT_ACCEPT),
      .wr_idx   (cfg_index),
      .wr_word  (conv_word),
      .commit   (commit),
      .coef_flat(coef_out)
   );

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(coef_out) |-> (set_done && !set_err));

   assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_done |-> $past(cfg_valid));

   assert_err_qual_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_err |-> set_done);

endmodule

// File: tb/cmx_coef_conv_tb.sv
module cmx_coef_conv_tb;
   localparam int N = 9;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_valid = 1'b0;
   logic [3:0]   cfg_index = '0;
   logic [63:0]  cfg_data = '0;
   logic         set_done;
   logic         set_err;
   logic [134:0] coef_out;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #5ns clk = ~clk;

   cmx_coef_conv u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_index(cfg_index),
      .cfg_data(cfg_data), .set_done(set_done), .set_err(set_err), .coef_out(coef_out)
   );

   // ---------------- behavioural reference ----------------
   logic [14:0] m_act [N];
   int          m_q[$];
   bit          m_bad, m_done, m_err;

   function automatic logic [15:0] ref_conv(logic [63:0] d);
      int mag, w;
      bit ov;
      mag = int'(d[34:20]);
      w   = d[63] ? ((32768 - mag) % 32768) : mag;
      ov  = d[63] != w[14];
      return {ov, w[14:0]};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_act[i]) m_act[i] = '0;
         m_q.delete(); m_bad = 0; m_done = 0; m_err = 0;
      end else begin
         logic [15:0] r;
         m_done = 0; m_err = 0;
         if (cfg_valid) begin
            if (int'(cfg_index) != m_q.size()) begin
               m_done = 1; m_err = 1; m_q.delete(); m_bad = 0;
            end else begin
               r = ref_conv(cfg_data);
               m_q.push_back(int'(r[14:0]));
               m_bad = m_bad | r[15];
               if (m_q.size() == N) begin
                  m_done = 1; m_err = m_bad;
                  if (!m_bad) for (int i = 0; i < N; i++) m_act[i] = 15'(m_q[i]);
                  m_q.delete(); m_bad = 0;
               end
            end
         end
      end
   end

   task automatic check(string tag, logic [134:0] act, logic [134:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [134:0] e;
         for (int i = 0; i < N; i++) e[i*15 +: 15] = m_act[i];
         check("R10 set_done", 135'(set_done), 135'(m_done));
         check("R6 set_err", 135'(set_err), 135'(m_err));
         check("R7/R8 coef_out", coef_out, e);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic drive(bit v, int idx, logic [63:0] d);
      cfg_valid = v; cfg_index = 4'(idx); cfg_data = d;
      @(negedge clk);
      cfg_valid = 0;
   endtask

   function automatic logic [63:0] mk(bit s, int field, logic [63:0] junk);
      logic [63:0] d;
      d = junk & ~64'h8000_0007_FFF0_0000;
      d[34:20] = 15'(field);
      d[63] = s;
      return d;
   endfunction

   task automatic word_is(string tag, int idx, int exp);
      check(tag, 135'(coef_out[idx*15 +: 15]), 135'(exp));
   endtask

   task automatic finish_run();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #1_000_000ns;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   logic [63:0] vals [N];
   logic [134:0] snap;

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset done", 135'(set_done), 135'(0));
      check("R1 reset err", 135'(set_err), 135'(0));
      check("R1 reset coef", coef_out, '0);
      rst_n = 1;
      @(negedge clk);
      check("R1 after release", {coef_out[133:0], set_done}, '0);

      // clean set with known words, gaps between strobes (R2, R3, R4, R9)
      vals[0] = mk(0, 16'h1000, 64'h7FFF_FFF8_000F_FFFF); // junk outside field (R2)
      vals[1] = mk(1, 16'h1000, 64'h0);                   // -> 0x7000 (R3)
      vals[2] = mk(1, 16'h2000, 64'h0);                   // -> 0x6000 accepted (R4)
      vals[3] = mk(0, 16'h0123, 64'h0000_0100_0000_0000);
      vals[4] = mk(1, 16'h4000, 64'h0);                   // -> 0x4000 accepted (R4)
      vals[5] = mk(0, 16'h3FFF, 64'h0);
      vals[6] = mk(1, 16'h0001, 64'h0);                   // -> 0x7FFF
      vals[7] = mk(0, 0, 64'h0);
      vals[8] = mk(0, 16'h0200, 64'h0);
      for (int i = 0; i < N; i++) begin
         drive(1, i, vals[i]);
         if (i % 3 == 1) drive(0, 5, 64'hFFFF_FFFF_FFFF_FFFF); // R9 idle junk
      end
      check("R6 clean done", {set_done, set_err}, 135'b10);
      word_is("R2 positive field", 0, 16'h1000);
      word_is("R3 negate 0x1000", 1, 16'h7000);
      word_is("R4 neg 0x2000 ok", 2, 16'h6000);
      word_is("R2 high bits ignored", 3, 16'h0123);
      word_is("R4 neg 0x4000 ok", 4, 16'h4000);
      word_is("R3 negate 1", 6, 16'h7FFF);
      word_is("R7 last word", 8, 16'h0200);
      @(negedge clk);
      check("R10 pulse one cycle", 135'(set_done), 135'(0));
      snap = coef_out;

      // positive overflow at the closing index (R4, R6, R8)
      for (int i = 0; i < N; i++)
         drive(1, i, (i == 8) ? mk(0, 16'h4000, 64'h0) : mk(0, i + 7, 64'h0));
      check("R4 last ovf err", {set_done, set_err}, 135'b11);
      check("R8 rejected hold", coef_out, snap);

      // negative zero field rejected (R4) back-to-back with next set (R9)
      for (int i = 0; i < N; i++)
         drive(1, i, (i == 3) ? mk(1, 0, 64'h0) : mk(0, 5, 64'h0));
      check("R4 neg zero err", {set_done, set_err}, 135'b11);
      check("R8 hold again", coef_out, snap);

      // abort on skipped index (R5), then restart at 0
      drive(1, 0, mk(0, 1, 0)); drive(1, 1, mk(0, 1, 0)); drive(1, 3, mk(0, 1, 0));
      check("R5 abort", {set_done, set_err}, 135'b11);
      check("R5 abort hold", coef_out, snap);
      for (int i = 0; i < N; i++) drive(1, i, mk(0, 100 + i, 64'h0));
      check("R5 restart clean", {set_done, set_err}, 135'b10);
      word_is("R7 restart word", 5, 105);

      // random sets, mostly back to back, with occasional faults
      for (int s = 0; s < 60; s++) begin
         for (int i = 0; i < N; i++) begin
            int f;
            int idx;
            f = ($urandom % 8 == 0) ? int'($urandom % 32768) : int'($urandom % 16384);
            idx = ($urandom % 40 == 0) ? int'($urandom % 9) : i;
            drive(1, idx, mk($urandom % 2 == 1, f, {$urandom, $urandom}));
            if ($urandom % 6 == 0) drive(0, 0, {$urandom, $urandom});
         end
      end
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule